// File: doc/BRIEF.md
# Cross Trigger Routing Matrix

This block connects a set of trigger inputs to a set of trigger outputs through a small number of broadcast channels. Each trigger input carries its own mask that chooses which channels it drives. Each trigger output carries its own mask that chooses which channels it listens to. A trigger output fires when any channel in its mask is active. Once fired, it stays set until an acknowledge write clears it. Software can also drive channels directly: it can hold them on with a set write and release them with a clear write, or assert them for a single cycle with a pulse write.

All configuration goes through a simple 32-bit register bus. The bus has a write strobe, a 12-bit byte address and a write-data word. Read data is combinational: it always reflects the register selected by the current address. The unit leaves reset locked and disabled. Writing a 32-bit key value to the lock-access register opens it for writes. Writing any other value to that register closes it again.

Top module: `xtrig_matrix`

## Requirements
- R1: After reset, the lock-status register (0xFB4, bit 0) reads 1, the control register (0x000) reads 0, every mask reads 0 and all trigger outputs are low.
- R2: Writing 0xC5ACCE55 to address 0xFB0 clears the locked flag. Writing any other value to that address sets the flag.
- R3: While the unit is locked, a write to any address other than 0xFB0 changes no register and no latched output.
- R4: A high trigger input n drives every channel whose bit is set in its mask at 0x020 + 4n. Register 0x138 reports, in bits 3:0, the channels driven by trigger inputs in the current cycle.
- R5: When any channel in the mask of trigger output n (at 0x0A0 + 4n) is active while the unit is enabled, output n is high from the next rising clock edge.
- R6: A fired output stays high after its channel goes inactive, until it is acknowledged. If an acknowledge and a new event for the same output land on the same edge, the output stays high.
- R7: Writing 1 to bit n of the acknowledge register (0x010) clears output n at that edge. Outputs whose bits are written as 0 keep their state.
- R8: Bit 0 of the control register (0x000) enables the unit. While it is 0, all trigger outputs read low, their latches are cleared, and register 0x13C reads 0. Events that arrive while the unit is disabled are not remembered after it is re-enabled.
- R9: A write to 0x014 holds the written channel bits active until a write to 0x018 releases them. Both addresses read back the held channels.
- R10: A write to 0x01C makes the written channel bits active for exactly the one cycle after the write edge.
- R11: Register 0x130 reports the trigger inputs. Register 0x134 reports the trigger outputs. Register 0x13C reports the active channels (input-driven, held and pulsed) while the unit is enabled.
- R12: Mask registers read back their channel bits in bits 3:0, at 0x020 + 4n for input n and 0x0A0 + 4n for output n. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| trig_in | input | 8 | Trigger input events |
| trig_out | output | 8 | Latched trigger outputs |

## Verification
A register write takes effect at the rising edge where its strobe is sampled. A read returns the new value in the same cycle that follows that edge, because read data is combinational. Output latches load one edge after the event that causes them. For an input trigger, that is the edge where the trigger is sampled. For a set or pulse write, it is one edge later, because the channel register sits in between. The bench model advances at every rising edge on the same inputs the design samples. It compares trig_out 3 ns after each edge, and it samples directed reads 2 ns after the falling edge at which it changes the address. Before each status read it waits enough idle cycles for these latencies.

// File: rtl/xtrig_pkg.sv
// Package: address map and key value shared by the cross trigger matrix.
// Assumes a 12-bit byte address on a 32-bit word bus.
package xtrig_pkg;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_CTRL    = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_ACK     = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_HOLDSET = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_HOLDCLR = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_PULSE   = 12'h01C;
    localparam logic [ADDR_W-1:0] OFS_INMASK  = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_OUTMASK = 12'h0A0;
    localparam logic [ADDR_W-1:0] OFS_ST_TIN  = 12'h130;
    localparam logic [ADDR_W-1:0] OFS_ST_TOUT = 12'h134;
    localparam logic [ADDR_W-1:0] OFS_ST_CHIN = 12'h138;
    localparam logic [ADDR_W-1:0] OFS_ST_CHOUT= 12'h13C;
    localparam logic [ADDR_W-1:0] OFS_KEY     = 12'hFB0;
    localparam logic [ADDR_W-1:0] OFS_LOCKST  = 12'hFB4;

    localparam logic [DATA_W-1:0] UNLOCK_KEY  = 32'hC5ACCE55;
endpackage

// File: rtl/xtrig_regs.sv
// Register file: lock flag, enable, per-line channel masks, held and
// pulsed application channels, and the acknowledge strobe.
// Assumes one write per cycle. The lock-access address is always writable.
module xtrig_regs
    import xtrig_pkg::*;
#(
    parameter int unsigned N_TIN  = 8,
    parameter int unsigned N_TOUT = 8,
    parameter int unsigned N_CH   = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [DATA_W-1:0]                wdata,
    output logic                             locked_q,
    output logic                             enable_q,
    output logic [N_TIN-1:0][N_CH-1:0]       in_mask_q,
    output logic [N_TOUT-1:0][N_CH-1:0]      out_mask_q,
    output logic [N_CH-1:0]                  hold_q,
    output logic [N_CH-1:0]                  pulse_q,
    output logic [N_TOUT-1:0]                ack
);
    logic wr_ok;

    // Writes that pass the lock gate.
    assign wr_ok = wr && !locked_q && (addr != OFS_KEY);

    // Acknowledge strobe, valid only in the write cycle.
    assign ack = (wr_ok && addr == OFS_ACK) ? wdata[N_TOUT-1:0] : '0;

    // Lock flag: the key opens the unit, any other value closes it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            locked_q <= 1'b1;
        else if (wr && addr == OFS_KEY)
            locked_q <= (wdata != UNLOCK_KEY);
    end

    // Global enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable_q <= 1'b0;
        else if (wr_ok && addr == OFS_CTRL)
            enable_q <= wdata[0];
    end

    // Held application channels: set and clear writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= '0;
        else if (wr_ok && addr == OFS_HOLDSET)
            hold_q <= hold_q | wdata[N_CH-1:0];
        else if (wr_ok && addr == OFS_HOLDCLR)
            hold_q <= hold_q & ~wdata[N_CH-1:0];
    end

    // Pulsed application channels, active for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse_q <= '0;
        else
            pulse_q <= (wr_ok && addr == OFS_PULSE) ? wdata[N_CH-1:0] : '0;
    end

    for (genvar i = 0; i < N_TIN; i++) begin : g_inmask
        localparam logic [ADDR_W-1:0] A = OFS_INMASK + ADDR_W'(4 * i);
        // Channel mask of trigger input i.
        always_ff @(posedge clk) begin
            if (!rst_n)
                in_mask_q[i] <= '0;
            else if (wr_ok && addr == A)
                in_mask_q[i] <= wdata[N_CH-1:0];
        end
    end

    for (genvar o = 0; o < N_TOUT; o++) begin : g_outmask
        localparam logic [ADDR_W-1:0] A = OFS_OUTMASK + ADDR_W'(4 * o);
        // Channel mask of trigger output o.
        always_ff @(posedge clk) begin
            if (!rst_n)
                out_mask_q[o] <= '0;
            else if (wr_ok && addr == A)
                out_mask_q[o] <= wdata[N_CH-1:0];
        end
    end

    AST_KEY_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OFS_KEY && wdata == UNLOCK_KEY) |=> !locked_q); // R2
    AST_BAD_KEY_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OFS_KEY && wdata != UNLOCK_KEY) |=> locked_q); // R2
    AST_LOCKED_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && locked_q && addr != OFS_KEY) |=>
        ($stable(enable_q) && $stable(hold_q) && $stable(in_mask_q) && $stable(out_mask_q))); // R3
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_q != '0 && !(wr && !locked_q && addr == OFS_PULSE)) |=> (pulse_q == '0)); // R10
endmodule

// File: rtl/xtrig_route.sv
// Routing network: input masks feed the channels, and output masks pick
// the channels for each output event. Purely combinational.
// Assumes the enable gate is applied here, so events never form while disabled.
module xtrig_route #(
    parameter int unsigned N_TIN  = 8,
    parameter int unsigned N_TOUT = 8,
    parameter int unsigned N_CH   = 4
) (
    input  logic [N_TIN-1:0]             trig_in,
    input  logic [N_TIN-1:0][N_CH-1:0]   in_mask,
    input  logic [N_TOUT-1:0][N_CH-1:0]  out_mask,
    input  logic [N_CH-1:0]              hold,
    input  logic [N_CH-1:0]              pulse,
    input  logic                         enable,
    output logic [N_CH-1:0]              ch_from_trig,
    output logic [N_CH-1:0]              ch_active,
    output logic [N_TOUT-1:0]            out_evt
);
    // OR the masks of all active trigger inputs into the channel vector.
    always_comb begin
        ch_from_trig = '0;
        for (int i = 0; i < N_TIN; i++)
            if (trig_in[i])
                ch_from_trig = ch_from_trig | in_mask[i];
    end

    assign ch_active = ch_from_trig | hold | pulse;

    for (genvar o = 0; o < N_TOUT; o++) begin : g_evt
        assign out_evt[o] = enable && ((ch_active & out_mask[o]) != '0);
    end

    always_comb begin
        if (!enable)
            AST_NO_EVT_DISABLED: assert (out_evt == '0); // R8
    end
endmodule

// File: rtl/xtrig_outlatch.sv
// Output latches: set by events, cleared by acknowledge or while disabled.
// Assumes set wins over acknowledge on the same edge.
module xtrig_outlatch #(
    parameter int unsigned N_TOUT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [N_TOUT-1:0] evt,
    input  logic [N_TOUT-1:0] ack,
    output logic [N_TOUT-1:0] lat_q,
    output logic [N_TOUT-1:0] trig_out
);
    // Latch events until acknowledged; drop everything while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lat_q <= '0;
        else if (!enable)
            lat_q <= '0;
        else
            lat_q <= (lat_q & ~ack) | evt;
    end

    assign trig_out = enable ? lat_q : '0;

    AST_FIRE_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((lat_q & $past(evt)) == $past(evt))); // R5
    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && (lat_q & ~ack) != '0) |=>
        ((lat_q & $past(lat_q & ~ack)) == $past(lat_q & ~ack))); // R6
    AST_DISABLED_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (lat_q == '0)); // R8
endmodule

// File: rtl/xtrig_matrix.sv
// Top: cross trigger matrix with register bus, lock, routing and latched
// outputs. Read data is a combinational decode of bus_addr.
// Assumes trigger inputs are already synchronous to clk.
module xtrig_matrix
    import xtrig_pkg::*;
#(
    parameter int unsigned N_TIN  = 8,
    parameter int unsigned N_TOUT = 8,
    parameter int unsigned N_CH   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [N_TIN-1:0]     trig_in,
    output logic [N_TOUT-1:0]    trig_out
);
    logic                         locked, enable;
    logic [N_TIN-1:0][N_CH-1:0]   in_mask;
    logic [N_TOUT-1:0][N_CH-1:0]  out_mask;
    logic [N_CH-1:0]              hold, pulse, ch_from_trig, ch_active;
    logic [N_TOUT-1:0]            ack, out_evt, lat;

    xtrig_regs #(.N_TIN(N_TIN), .N_TOUT(N_TOUT), .N_CH(N_CH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .locked_q(locked), .enable_q(enable), .in_mask_q(in_mask),
        .out_mask_q(out_mask), .hold_q(hold), .pulse_q(pulse), .ack(ack)
    );

    xtrig_route #(.N_TIN(N_TIN), .N_TOUT(N_TOUT), .N_CH(N_CH)) u_route (
        .trig_in(trig_in), .in_mask(in_mask), .out_mask(out_mask),
        .hold(hold), .pulse(pulse), .enable(enable),
        .ch_from_trig(ch_from_trig), .ch_active(ch_active), .out_evt(out_evt)
    );

    xtrig_outlatch #(.N_TOUT(N_TOUT)) u_lat (
        .clk(clk), .rst_n(rst_n), .enable(enable), .evt(out_evt), .ack(ack),
        .lat_q(lat), .trig_out(trig_out)
    );

    // Read decode of the current address.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL:     bus_rdata[0] = enable;
            OFS_HOLDSET,
            OFS_HOLDCLR:  bus_rdata[N_CH-1:0] = hold;
            OFS_ST_TIN:   bus_rdata[N_TIN-1:0] = trig_in;
            OFS_ST_TOUT:  bus_rdata[N_TOUT-1:0] = trig_out;
            OFS_ST_CHIN:  bus_rdata[N_CH-1:0] = ch_from_trig;
            OFS_ST_CHOUT: bus_rdata[N_CH-1:0] = enable ? ch_active : '0;
            OFS_LOCKST:   bus_rdata[0] = locked;
            default:      bus_rdata = '0;
        endcase
        for (int i = 0; i < N_TIN; i++)
            if (bus_addr == OFS_INMASK + ADDR_W'(4 * i))
                bus_rdata[N_CH-1:0] = in_mask[i];
        for (int o = 0; o < N_TOUT; o++)
            if (bus_addr == OFS_OUTMASK + ADDR_W'(4 * o))
                bus_rdata[N_CH-1:0] = out_mask[o];
    end

    AST_OUT_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (trig_out == '0)); // R8
endmodule

// File: tb/xtrig_matrix_test.sv
module xtrig_matrix_test;
    localparam int NI = 8, NO = 8, NC = 4;
    localparam logic [31:0] KEY = 32'hC5ACCE55;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  tin = '0;
    logic [7:0]  tout;

    int checks = 0, errors = 0, cycles = 0;
    string phase = "R1";
    bit done = 0;

    xtrig_matrix #(.N_TIN(NI), .N_TOUT(NO), .N_CH(NC)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_in(tin), .trig_out(tout)
    );

    always #5 clk = ~clk;

    // Behavioural reference model.
    bit       m_locked, m_en;
    bit [3:0] m_in [8];
    bit [3:0] m_out [8];
    bit [3:0] m_hold, m_pulse;
    bit [7:0] m_lat;

    function automatic bit [3:0] chin_now();
        bit [3:0] c = 0;
        for (int i = 0; i < 8; i++) if (tin[i]) c |= m_in[i];
        return c;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_locked = 1; m_en = 0; m_hold = 0; m_pulse = 0; m_lat = 0;
            for (int i = 0; i < 8; i++) begin m_in[i] = 0; m_out[i] = 0; end
        end else begin
            bit [3:0] act;
            bit [7:0] evt, ackv;
            bit wok;
            act = chin_now() | m_hold | m_pulse;
            evt = 0;
            for (int o = 0; o < 8; o++) if (m_en && (act & m_out[o]) != 0) evt[o] = 1;
            wok = bus_wr && !m_locked && bus_addr != 12'hFB0;
            ackv = (wok && bus_addr == 12'h010) ? bus_wdata[7:0] : 8'h0;
            m_lat = m_en ? ((m_lat & ~ackv) | evt) : 8'h0;
            m_pulse = (wok && bus_addr == 12'h01C) ? bus_wdata[3:0] : 4'h0;
            if (bus_wr && bus_addr == 12'hFB0) m_locked = (bus_wdata != KEY);
            if (wok) begin
                if (bus_addr == 12'h000) m_en = bus_wdata[0];
                if (bus_addr == 12'h014) m_hold |= bus_wdata[3:0];
                if (bus_addr == 12'h018) m_hold &= ~bus_wdata[3:0];
                for (int i = 0; i < 8; i++) begin
                    if (bus_addr == 12'h020 + 12'(4*i)) m_in[i] = bus_wdata[3:0];
                    if (bus_addr == 12'h0A0 + 12'(4*i)) m_out[i] = bus_wdata[3:0];
                end
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare the output with the model on every clock.
    always @(posedge clk) begin
        #3;
        if (!done) check(phase, {24'h0, tout}, {24'h0, (m_en ? m_lat : 8'h0)});
    end

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
            finish_run();
        end
    end

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic rd(string req, logic [11:0] a, logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #2;
        check(req, bus_rdata, exp);
        bus_addr = '0;
    endtask

    task automatic tpulse(logic [7:0] v);
        @(negedge clk); tin = v;
        @(negedge clk); tin = 0;
    endtask

    initial begin
        idle(4);
        rst_n = 1;
        // R1: reset state
        phase = "R1";
        rd("R1", 12'hFB4, 1); rd("R1", 12'h000, 0); rd("R1", 12'h020, 0);
        rd("R1", 12'h0A0, 0); rd("R1", 12'h134, 0);
        // R3: writes while locked are ignored
        phase = "R3";
        wr(12'h000, 1); rd("R3", 12'h000, 0);
        wr(12'h020, 2); rd("R3", 12'h020, 0);
        // R2: key handling
        phase = "R2";
        wr(12'hFB0, KEY);   rd("R2", 12'hFB4, 0);
        wr(12'hFB0, 32'h1); rd("R2", 12'hFB4, 1);
        wr(12'hFB0, KEY);   rd("R2", 12'hFB4, 0);
        // R12: mask programming and readback
        phase = "R12";
        wr(12'h020, 32'h2); wr(12'h028, 32'h4);
        wr(12'h0AC, 32'h2); wr(12'h0B4, 32'hF6);
        rd("R12", 12'h020, 2); rd("R12", 12'h028, 4);
        rd("R12", 12'h0AC, 2); rd("R12", 12'h0B4, 6); rd("R12", 12'h300, 0);
        wr(12'h000, 1); rd("R8", 12'h000, 1);
        // R4/R5: input 2 drives channel 2, reaching output 5 only
        phase = "R5";
        tpulse(8'h04); idle(1);
        rd("R5", 12'h134, 32'h20);
        wr(12'h010, 32'h20); rd("R7", 12'h134, 0);
        // R4/R11: hold input 0 and read status
        phase = "R4";
        @(negedge clk); tin = 8'h01; idle(1);
        rd("R11", 12'h130, 1); rd("R4", 12'h138, 2); rd("R11", 12'h13C, 2);
        rd("R11", 12'h134, 32'h28);
        // R6: acknowledge while the event persists keeps the output set
        phase = "R6";
        wr(12'h010, 32'h28); rd("R6", 12'h134, 32'h28);
        @(negedge clk); tin = 0; idle(2);
        rd("R6", 12'h134, 32'h28); rd("R4", 12'h138, 0);
        // R7: selective acknowledge
        phase = "R7";
        wr(12'h010, 32'h08); rd("R7", 12'h134, 32'h20);
        wr(12'h010, 32'h20); rd("R7", 12'h134, 0);
        // R9: held channels
        phase = "R9";
        wr(12'h014, 32'h4); idle(1);
        rd("R9", 12'h014, 4); rd("R9", 12'h134, 32'h20);
        wr(12'h010, 32'h20); idle(1); rd("R9", 12'h134, 32'h20);
        wr(12'h018, 32'h4); wr(12'h010, 32'h20); idle(1);
        rd("R9", 12'h134, 0); rd("R9", 12'h018, 0);
        // R10: pulsed channels
        phase = "R10";
        wr(12'h01C, 32'h2); idle(1);
        rd("R10", 12'h134, 32'h28); rd("R10", 12'h13C, 0);
        wr(12'h010, 32'h28); idle(1); rd("R10", 12'h134, 0);
        // R8: disable
        phase = "R8";
        @(negedge clk); tin = 8'h01; idle(1);
        rd("R8", 12'h134, 32'h28);
        wr(12'h000, 0); rd("R8", 12'h134, 0); rd("R8", 12'h13C, 0);
        idle(2); wr(12'h000, 1); idle(1);
        rd("R8", 12'h134, 32'h28);
        @(negedge clk); tin = 0;
        wr(12'h010, 32'h28);
        wr(12'h000, 0); tpulse(8'h05); wr(12'h000, 1); idle(2);
        rd("R8", 12'h134, 0);
        // R3: locked again, acknowledge and mask writes ignored
        phase = "R3";
        tpulse(8'h01); wr(12'hFB0, 32'h0); rd("R3", 12'hFB4, 1);
        wr(12'h010, 32'h28); idle(1); rd("R3", 12'h134, 32'h28);
        wr(12'h020, 32'h0); rd("R3", 12'h020, 2);
        wr(12'h000, 0); rd("R3", 12'h000, 1);
        wr(12'h014, 32'h1); rd("R3", 12'h014, 0);
        idle(3);
        finish_run();
    end
endmodule